// File: doc/BRIEF.md
# Hashed Page Table Group Searcher

This block resolves translation-buffer misses against a hashed page table held in memory. A miss arrives as a 40-bit virtual page number together with the table base address and a table-size mask. The block hashes the page number to a primary group of eight entries and fetches those entries one at a time over a memory read port that allows a single outstanding read. It compares each returned entry against the request. If none of the eight matches, it repeats the scan on a secondary group whose index is the complement of the primary one. The first matching entry ends the search and returns its physical page number. If all sixteen entries fail, the block returns a trap indication so that software can handle the miss.

Requests and responses use valid/ready handshakes. The memory side issues an address with a valid/ready pair and expects one data beat back for each accepted address. The block never writes the table. Inserting entries, evicting them and maintaining usage bits are left to software.

Top module: `hpt_group_walker`

## Requirements
- R1: Out of reset, and whenever no search is in progress, `req_ready` is 1 while `resp_valid` and `rd_req_valid` are 0. A request is accepted only in that state.
- R2: The primary group index is (vpn[9:0] XOR vpn[19:10] XOR vpn[29:20] XOR vpn[39:30]) AND mask. A group starts at base OR (index << 6). Slot n of a group is read at group start + 8*n, so every read address is 8-byte aligned.
- R3: The secondary group index is (NOT primary index) AND mask.
- R4: Reads run in a fixed order: primary slots 0 to 7, then secondary slots 0 to 7. No new address is issued until the data for the previous one has returned.
- R5: An entry is 64 bits. It matches only when bit 63 (valid) is 1, bit 62 (group select: 0 primary, 1 secondary) equals the group being searched, and bits 61:32 equal vpn[39:10]. Bits 31:28 are ignored.
- R6: The search stops at the first matching entry. The response carries `resp_hit`=1, the entry's bits 27:0 as `resp_ppn`, the slot index and a secondary-group flag. The number of reads issued equals 8*group + slot + 1.
- R7: If no entry matches, the response comes after exactly 16 reads with `resp_trap`=1, `resp_hit`=0 and `resp_ppn`=0. Exactly one of hit and trap is set in every response.
- R8: A pending read address is held stable until it is accepted. A response and its fields are held until `resp_ready` is 1.
- R9: The virtual page number, base and mask are captured when a request is accepted. Changes to these inputs during a search have no effect on that search.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Miss request valid |
| req_ready | output | 1 | Block can accept a request |
| req_vpn | input | 40 | Virtual page number to resolve |
| req_base | input | 48 | Table base byte address |
| req_mask | input | 10 | Group index mask (table size) |
| rd_req_valid | output | 1 | Memory read address valid |
| rd_req_ready | input | 1 | Memory accepts the address |
| rd_addr | output | 48 | Byte address of the entry to read |
| rd_resp_valid | input | 1 | Read data valid |
| rd_resp_data | input | 64 | Entry contents |
| resp_valid | output | 1 | Search result valid |
| resp_ready | input | 1 | Consumer accepts the result |
| resp_hit | output | 1 | Matching entry found |
| resp_trap | output | 1 | No match, trap to software |
| resp_ppn | output | 28 | Physical page number on a hit |
| resp_slot | output | 3 | Slot index of the matching entry |
| resp_secondary | output | 1 | Match came from the secondary group |

## Verification
The assertions check the following on every cycle: the idle handshake state, address alignment, the single-outstanding rule on the memory port, stable addresses and responses under back-pressure, exactly one of hit and trap in each response, and a trap only after sixteen reads. Only the bench scenarios can show the remaining behaviour. These are the hash and address arithmetic, the strict slot and group order, the choice of the first match over later duplicates, the rejection of entries that fail on valid bit, tag or group select, and the capture of the request inputs. The bench shows them by placing a match in each of the sixteen positions surrounded by near-miss entries.

// File: rtl/hpt_pkg.sv
package hpt_pkg;

  typedef enum logic [1:0] {
    WALK_IDLE  = 2'd0,
    WALK_ISSUE = 2'd1,
    WALK_WAIT  = 2'd2,
    WALK_DONE  = 2'd3
  } walk_state_e;

endpackage

// File: rtl/hpt_rst_sync.sv
module hpt_rst_sync (
  input  logic clk,
  input  logic rst_n_in,
  output logic rst_n_out
);

  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n_in) begin
    if (!rst_n_in) begin
      sync_q <= 2'b00;
    end else begin
      sync_q <= {sync_q[0], 1'b1};
    end
  end

  assign rst_n_out = sync_q[1];

endmodule

// File: rtl/hpt_hash.sv
module hpt_hash #(
  parameter int VPN_W  = 40,
  parameter int HASH_W = 10
) (
  input  logic [VPN_W-1:0]  vpn,
  input  logic [HASH_W-1:0] mask,
  output logic [HASH_W-1:0] prim_idx,
  output logic [HASH_W-1:0] sec_idx
);

  localparam int TAG_W  = VPN_W - HASH_W;
  localparam int NCHUNK = (TAG_W + HASH_W - 1) / HASH_W;
  localparam int PAD_W  = NCHUNK * HASH_W;

  logic [PAD_W-1:0]  tag_pad;
  logic [HASH_W-1:0] fold;

  assign tag_pad = PAD_W'(vpn[VPN_W-1:HASH_W]);

  // Fold the upper page bits down to the index width.
  always_comb begin
    fold = '0;
    for (int i = 0; i < NCHUNK; i++) begin
      fold = fold ^ tag_pad[i*HASH_W +: HASH_W];
    end
  end

  assign prim_idx = (vpn[HASH_W-1:0] ^ fold) & mask;
  assign sec_idx  = (~prim_idx) & mask;

endmodule

// File: rtl/hpt_entry_match.sv
module hpt_entry_match #(
  parameter int ENTRY_W = 64,
  parameter int TAG_W   = 30,
  parameter int PPN_W   = 28
) (
  input  logic [ENTRY_W-1:0] entry,
  input  logic [TAG_W-1:0]   want_tag,
  input  logic               want_sec,
  output logic               match,
  output logic [PPN_W-1:0]   ppn
);

  localparam int VLD_BIT = ENTRY_W - 1;
  localparam int SEL_BIT = ENTRY_W - 2;
  localparam int TAG_HI  = ENTRY_W - 3;
  localparam int TAG_LO  = TAG_HI - TAG_W + 1;
  localparam int RSV_W   = TAG_LO - PPN_W;

  logic             ent_vld;
  logic             ent_sel;
  logic [TAG_W-1:0] ent_tag;
  logic [RSV_W-1:0] unused_rsv;

  assign ent_vld    = entry[VLD_BIT];
  assign ent_sel    = entry[SEL_BIT];
  assign ent_tag    = entry[TAG_HI:TAG_LO];
  assign unused_rsv = entry[TAG_LO-1:PPN_W];
  assign ppn        = entry[PPN_W-1:0];

  assign match = ent_vld && (ent_sel == want_sec) && (ent_tag == want_tag);

endmodule

// File: rtl/hpt_walk_ctrl.sv
module hpt_walk_ctrl
  import hpt_pkg::*;
#(
  parameter int VPN_W     = 40,
  parameter int HASH_W    = 10,
  parameter int ADDR_W    = 48,
  parameter int PPN_W     = 28,
  parameter int GROUP_N   = 8,
  parameter int ENTRY_B   = 8
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 req_valid,
  output logic                 req_ready,
  input  logic [VPN_W-1:0]     req_vpn,
  input  logic [ADDR_W-1:0]    req_base,
  input  logic [HASH_W-1:0]    req_mask,
  output logic [VPN_W-1:0]     lat_vpn,
  output logic [HASH_W-1:0]    lat_mask,
  input  logic [HASH_W-1:0]    prim_idx,
  input  logic [HASH_W-1:0]    sec_idx,
  output logic                 phase_sec,
  output logic                 rd_req_valid,
  input  logic                 rd_req_ready,
  output logic [ADDR_W-1:0]    rd_addr,
  input  logic                 rd_resp_valid,
  input  logic                 ent_match,
  input  logic [PPN_W-1:0]     ent_ppn,
  output logic                 resp_valid,
  input  logic                 resp_ready,
  output logic                 resp_hit,
  output logic                 resp_trap,
  output logic [PPN_W-1:0]     resp_ppn,
  output logic [$clog2(GROUP_N)-1:0] resp_slot,
  output logic                 resp_secondary
);

  localparam int SLOT_W    = $clog2(GROUP_N);
  localparam int ESHIFT    = $clog2(ENTRY_B);
  localparam int GSHIFT    = $clog2(GROUP_N * ENTRY_B);
  localparam logic [SLOT_W-1:0] LAST_SLOT = SLOT_W'(GROUP_N - 1);

  walk_state_e       state_q, state_d;
  logic [SLOT_W-1:0] slot_q, slot_d;
  logic              phase_q, phase_d;
  logic [VPN_W-1:0]  vpn_q;
  logic [ADDR_W-1:0] base_q;
  logic [HASH_W-1:0] mask_q;
  logic              hit_q, hit_d;
  logic [PPN_W-1:0]  ppn_q, ppn_d;
  logic [SLOT_W-1:0] rslot_q;
  logic              rsec_q;
  logic              cap_req;
  logic              cap_resp;
  logic              step_en;

  logic [HASH_W-1:0] cur_idx;
  logic [ADDR_W-1:0] grp_addr;

  // Next-state logic
  always_comb begin
    state_d  = state_q;
    slot_d   = slot_q;
    phase_d  = phase_q;
    hit_d    = hit_q;
    ppn_d    = ppn_q;
    cap_req  = 1'b0;
    cap_resp = 1'b0;
    step_en  = 1'b0;
    unique case (state_q)
      WALK_IDLE: begin
        if (req_valid) begin
          cap_req = 1'b1;
          step_en = 1'b1;
          slot_d  = '0;
          phase_d = 1'b0;
          state_d = WALK_ISSUE;
        end
      end
      WALK_ISSUE: begin
        if (rd_req_ready) begin
          state_d = WALK_WAIT;
        end
      end
      WALK_WAIT: begin
        if (rd_resp_valid) begin
          if (ent_match) begin
            cap_resp = 1'b1;
            hit_d    = 1'b1;
            ppn_d    = ent_ppn;
            state_d  = WALK_DONE;
          end else if (slot_q == LAST_SLOT) begin
            if (phase_q) begin
              cap_resp = 1'b1;
              hit_d    = 1'b0;
              ppn_d    = '0;
              state_d  = WALK_DONE;
            end else begin
              step_en = 1'b1;
              phase_d = 1'b1;
              slot_d  = '0;
              state_d = WALK_ISSUE;
            end
          end else begin
            step_en = 1'b1;
            slot_d  = slot_q + 1'b1;
            state_d = WALK_ISSUE;
          end
        end
      end
      WALK_DONE: begin
        if (resp_ready) begin
          state_d = WALK_IDLE;
        end
      end
      default: state_d = WALK_IDLE;
    endcase
  end

  // Control registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= WALK_IDLE;
      slot_q  <= '0;
      phase_q <= 1'b0;
    end else begin
      state_q <= state_d;
      if (step_en) begin
        slot_q  <= slot_d;
        phase_q <= phase_d;
      end
    end
  end

  // Captured request
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vpn_q  <= '0;
      base_q <= '0;
      mask_q <= '0;
    end else if (cap_req) begin
      vpn_q  <= req_vpn;
      base_q <= req_base;
      mask_q <= req_mask;
    end
  end

  // Result registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hit_q   <= 1'b0;
      ppn_q   <= '0;
      rslot_q <= '0;
      rsec_q  <= 1'b0;
    end else if (cap_resp) begin
      hit_q   <= hit_d;
      ppn_q   <= ppn_d;
      rslot_q <= slot_q;
      rsec_q  <= phase_q;
    end
  end

  assign cur_idx  = phase_q ? sec_idx : prim_idx;
  assign grp_addr = base_q | (ADDR_W'(cur_idx) << GSHIFT);
  assign rd_addr  = grp_addr + (ADDR_W'(slot_q) << ESHIFT);

  assign lat_vpn   = vpn_q;
  assign lat_mask  = mask_q;
  assign phase_sec = phase_q;

  assign req_ready      = (state_q == WALK_IDLE);
  assign rd_req_valid   = (state_q == WALK_ISSUE);
  assign resp_valid     = (state_q == WALK_DONE);
  assign resp_hit       = resp_valid && hit_q;
  assign resp_trap      = resp_valid && !hit_q;
  assign resp_ppn       = ppn_q;
  assign resp_slot      = rslot_q;
  assign resp_secondary = rsec_q;

endmodule

// File: rtl/hpt_group_walker.sv
module hpt_group_walker #(
  parameter int VPN_W   = 40,
  parameter int HASH_W  = 10,
  parameter int ADDR_W  = 48,
  parameter int PPN_W   = 28,
  parameter int ENTRY_W = 64,
  parameter int GROUP_N = 8,
  parameter int ENTRY_B = 8
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       req_valid,
  output logic                       req_ready,
  input  logic [VPN_W-1:0]           req_vpn,
  input  logic [ADDR_W-1:0]          req_base,
  input  logic [HASH_W-1:0]          req_mask,
  output logic                       rd_req_valid,
  input  logic                       rd_req_ready,
  output logic [ADDR_W-1:0]          rd_addr,
  input  logic                       rd_resp_valid,
  input  logic [ENTRY_W-1:0]         rd_resp_data,
  output logic                       resp_valid,
  input  logic                       resp_ready,
  output logic                       resp_hit,
  output logic                       resp_trap,
  output logic [PPN_W-1:0]           resp_ppn,
  output logic [$clog2(GROUP_N)-1:0] resp_slot,
  output logic                       resp_secondary
);

  localparam int TAG_W = VPN_W - HASH_W;

  logic              rst_n_sync;
  logic [VPN_W-1:0]  lat_vpn;
  logic [HASH_W-1:0] lat_mask;
  logic [HASH_W-1:0] prim_idx;
  logic [HASH_W-1:0] sec_idx;
  logic              phase_sec;
  logic              ent_match;
  logic [PPN_W-1:0]  ent_ppn;

  hpt_rst_sync u_rst (
    .clk       (clk),
    .rst_n_in  (rst_n),
    .rst_n_out (rst_n_sync)
  );

  hpt_hash #(
    .VPN_W  (VPN_W),
    .HASH_W (HASH_W)
  ) u_hash (
    .vpn      (lat_vpn),
    .mask     (lat_mask),
    .prim_idx (prim_idx),
    .sec_idx  (sec_idx)
  );

  hpt_entry_match #(
    .ENTRY_W (ENTRY_W),
    .TAG_W   (TAG_W),
    .PPN_W   (PPN_W)
  ) u_match (
    .entry    (rd_resp_data),
    .want_tag (lat_vpn[VPN_W-1:HASH_W]),
    .want_sec (phase_sec),
    .match    (ent_match),
    .ppn      (ent_ppn)
  );

  hpt_walk_ctrl #(
    .VPN_W   (VPN_W),
    .HASH_W  (HASH_W),
    .ADDR_W  (ADDR_W),
    .PPN_W   (PPN_W),
    .GROUP_N (GROUP_N),
    .ENTRY_B (ENTRY_B)
  ) u_ctrl (
    .clk            (clk),
    .rst_n          (rst_n_sync),
    .req_valid      (req_valid),
    .req_ready      (req_ready),
    .req_vpn        (req_vpn),
    .req_base       (req_base),
    .req_mask       (req_mask),
    .lat_vpn        (lat_vpn),
    .lat_mask       (lat_mask),
    .prim_idx       (prim_idx),
    .sec_idx        (sec_idx),
    .phase_sec      (phase_sec),
    .rd_req_valid   (rd_req_valid),
    .rd_req_ready   (rd_req_ready),
    .rd_addr        (rd_addr),
    .rd_resp_valid  (rd_resp_valid),
    .ent_match      (ent_match),
    .ent_ppn        (ent_ppn),
    .resp_valid     (resp_valid),
    .resp_ready     (resp_ready),
    .resp_hit       (resp_hit),
    .resp_trap      (resp_trap),
    .resp_ppn       (resp_ppn),
    .resp_slot      (resp_slot),
    .resp_secondary (resp_secondary)
  );

endmodule

// File: rtl/hpt_group_walker_chk.sv
module hpt_group_walker_chk #(
  parameter int ADDR_W  = 48,
  parameter int PPN_W   = 28,
  parameter int GROUP_N = 8,
  parameter int ENTRY_B = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              req_valid,
  input logic              req_ready,
  input logic              rd_req_valid,
  input logic              rd_req_ready,
  input logic [ADDR_W-1:0] rd_addr,
  input logic              rd_resp_valid,
  input logic              resp_valid,
  input logic              resp_ready,
  input logic              resp_hit,
  input logic              resp_trap,
  input logic [PPN_W-1:0]  resp_ppn
);

  localparam int ESHIFT = $clog2(ENTRY_B);
  localparam int MAXRD  = 2 * GROUP_N;
  localparam int CNT_W  = $clog2(MAXRD + 2) + 1;

  logic             outst_q;
  logic [CNT_W-1:0] reads_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      outst_q <= 1'b0;
      reads_q <= '0;
    end else begin
      if (rd_req_valid && rd_req_ready) begin
        outst_q <= 1'b1;
      end else if (rd_resp_valid) begin
        outst_q <= 1'b0;
      end
      if (req_valid && req_ready) begin
        reads_q <= '0;
      end else if (rd_req_valid && rd_req_ready) begin
        reads_q <= reads_q + 1'b1;
      end
    end
  end

  assert_idle_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> (!resp_valid && !rd_req_valid));

  assert_addr_align_R2: assert property (@(posedge clk) disable iff (!rst_n)
    rd_req_valid |-> (rd_addr[ESHIFT-1:0] == '0));

  assert_one_outstanding_R4: assert property (@(posedge clk) disable iff (!rst_n)
    rd_req_valid |-> !outst_q);

  assert_budget_R6: assert property (@(posedge clk) disable iff (!rst_n)
    resp_valid |-> (reads_q <= CNT_W'(MAXRD)));

  assert_resp_kind_R7: assert property (@(posedge clk) disable iff (!rst_n)
    resp_valid |-> $onehot({resp_hit, resp_trap}));

  assert_trap_after_all_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (resp_valid && resp_trap) |-> (reads_q == CNT_W'(MAXRD)));

  assert_rd_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_req_valid && !rd_req_ready) |=> (rd_req_valid && $stable(rd_addr)));

  assert_resp_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (resp_valid && !resp_ready) |=>
      (resp_valid && $stable(resp_ppn) && $stable(resp_hit)));

endmodule

bind hpt_group_walker hpt_group_walker_chk #(
  .ADDR_W  (ADDR_W),
  .PPN_W   (PPN_W),
  .GROUP_N (GROUP_N),
  .ENTRY_B (ENTRY_B)
) u_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .req_valid     (req_valid),
  .req_ready     (req_ready),
  .rd_req_valid  (rd_req_valid),
  .rd_req_ready  (rd_req_ready),
  .rd_addr       (rd_addr),
  .rd_resp_valid (rd_resp_valid),
  .resp_valid    (resp_valid),
  .resp_ready    (resp_ready),
  .resp_hit      (resp_hit),
  .resp_trap     (resp_trap),
  .resp_ppn      (resp_ppn)
);

// File: tb/hpt_group_walker_test.sv
module hpt_group_walker_test;

  logic        clk;
  logic        rst_n;
  logic        req_valid;
  logic        req_ready;
  logic [39:0] req_vpn;
  logic [47:0] req_base;
  logic [9:0]  req_mask;
  logic        rd_req_valid;
  logic        rd_req_ready;
  logic [47:0] rd_addr;
  logic        rd_resp_valid;
  logic [63:0] rd_resp_data;
  logic        resp_valid;
  logic        resp_ready;
  logic        resp_hit;
  logic        resp_trap;
  logic [27:0] resp_ppn;
  logic [2:0]  resp_slot;
  logic        resp_secondary;

  int n_vec;
  int n_bad;

  logic [63:0] mem [logic [47:0]];
  logic [47:0] alog [0:31];
  int          rd_cnt;
  logic [3:0]  stall_q;
  int          cyc;

  hpt_group_walker uut (
    .clk            (clk),
    .rst_n          (rst_n),
    .req_valid      (req_valid),
    .req_ready      (req_ready),
    .req_vpn        (req_vpn),
    .req_base       (req_base),
    .req_mask       (req_mask),
    .rd_req_valid   (rd_req_valid),
    .rd_req_ready   (rd_req_ready),
    .rd_addr        (rd_addr),
    .rd_resp_valid  (rd_resp_valid),
    .rd_resp_data   (rd_resp_data),
    .resp_valid     (resp_valid),
    .resp_ready     (resp_ready),
    .resp_hit       (resp_hit),
    .resp_trap      (resp_trap),
    .resp_ppn       (resp_ppn),
    .resp_slot      (resp_slot),
    .resp_secondary (resp_secondary)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  // Memory model: one-cycle read latency, periodic address stalls.
  assign rd_req_ready = (stall_q[1:0] != 2'b11);

  always @(posedge clk) begin
    stall_q <= stall_q + 4'd1;
    if (req_valid && req_ready) rd_cnt <= 0;
    if (rd_req_valid && rd_req_ready) begin
      rd_resp_valid <= 1'b1;
      rd_resp_data  <= mem.exists(rd_addr) ? mem[rd_addr] : 64'h0;
      if (rd_cnt < 32) alog[rd_cnt] <= rd_addr;
      rd_cnt <= rd_cnt + 1;
    end else begin
      rd_resp_valid <= 1'b0;
    end
  end

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    n_vec++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [9:0] prim_of(input logic [39:0] v, input logic [9:0] m);
    return (v[9:0] ^ v[19:10] ^ v[29:20] ^ v[39:30]) & m;
  endfunction

  function automatic logic [47:0] slot_addr(input logic [47:0] b, input logic [9:0] h, input int sl);
    return (b | (48'(h) << 6)) + 48'(sl) * 48'd8;
  endfunction

  // R5 layout: [63] valid, [62] group select, [61:32] tag, [31:28] ignored, [27:0] ppn
  function automatic logic [63:0] mk(input bit vld, input bit sel, input logic [29:0] tg, input logic [27:0] pp);
    return {vld, sel, tg, 4'hA, pp};
  endfunction

  task automatic run_case(input logic [39:0] v, input logic [47:0] b, input logic [9:0] m, input int pos);
    logic [9:0]  hp;
    logic [9:0]  hs;
    logic [27:0] good;
    logic [27:0] held;
    int          exp_rd;
    int          bad_addr;
    int          w;
    hp = prim_of(v, m);
    hs = (~hp) & m;                                   // R3
    good = 28'h5A50000 ^ 28'(pos * 37) ^ v[27:0];
    mem.delete();
    for (int k = 0; k < 16; k++) begin
      int g  = k / 8;
      int sl = k % 8;
      int kind = (k + int'(v[1:0])) % 3;
      logic [47:0] a = slot_addr(b, g ? hs : hp, sl);
      // R5 near-misses: invalid, wrong tag, wrong group select
      if (kind == 0)      mem[a] = mk(1'b0, g[0], v[39:10], 28'h1111111);
      else if (kind == 1) mem[a] = mk(1'b1, g[0], v[39:10] ^ 30'h1, 28'h2222222);
      else                mem[a] = mk(1'b1, ~g[0], v[39:10], 28'h3333333);
    end
    if (pos >= 0) begin
      int g  = pos / 8;
      int sl = pos % 8;
      mem[slot_addr(b, g ? hs : hp, sl)] = mk(1'b1, g[0], v[39:10], good);
      // R6 later duplicates must not be chosen
      if (sl < 7) mem[slot_addr(b, g ? hs : hp, sl + 1)] = mk(1'b1, g[0], v[39:10], ~good);
      if (g == 0) mem[slot_addr(b, hs, 0)] = mk(1'b1, 1'b1, v[39:10], ~good);
    end
    exp_rd = (pos >= 0) ? pos + 1 : 16;

    @(negedge clk);
    req_vpn = v; req_base = b; req_mask = m; req_valid = 1'b1;
    w = 0;
    while (!req_ready && w < 100) begin @(negedge clk); w++; end
    @(negedge clk);
    req_valid = 1'b0;
    // R9: scramble inputs during the search
    req_vpn = ~v; req_base = b ^ 48'h0000_00FF_FFC0; req_mask = ~m;
    w = 0;
    while (!resp_valid && w < 400) begin @(negedge clk); w++; end
    held = resp_ppn;
    @(negedge clk);
    @(negedge clk);
    chk(resp_valid && resp_ppn == held, "R8 response held", {35'h0, resp_valid, resp_ppn}, {35'h0, 1'b1, held});
    if (pos >= 0) begin
      chk(resp_hit && !resp_trap, "R6 hit reported", {resp_hit, resp_trap}, 2'b10);
      chk(resp_ppn == good, "R6 ppn of first match", resp_ppn, good);
      chk(resp_slot == 3'(pos % 8) && resp_secondary == (pos >= 8), "R6 slot and group",
          {resp_secondary, resp_slot}, {(pos >= 8), 3'(pos % 8)});
    end else begin
      chk(resp_trap && !resp_hit, "R7 trap reported", {resp_hit, resp_trap}, 2'b01);
      chk(resp_ppn == 28'h0, "R7 ppn zero on trap", resp_ppn, 0);
    end
    chk(rd_cnt == exp_rd, pos >= 0 ? "R6 read count" : "R7 read count", rd_cnt, exp_rd);
    bad_addr = 0;
    for (int k = 0; k < exp_rd && k < 32; k++) begin
      if (alog[k] != slot_addr(b, (k >= 8) ? hs : hp, k % 8)) bad_addr++;
    end
    chk(bad_addr == 0, "R2 R3 R4 R9 address sequence", bad_addr, 0);
    resp_ready = 1'b1;
    @(negedge clk);
    resp_ready = 1'b0;
    chk(req_ready && !resp_valid && !rd_req_valid, "R1 idle after response",
        {req_ready, resp_valid, rd_req_valid}, 3'b100);
  endtask

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 150000) begin
      n_bad++;
      $display("FAIL watchdog actual=%0d expected=<150000", cyc);
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end

  initial begin
    logic [39:0] vpns  [0:2];
    logic [47:0] bases [0:2];
    logic [9:0]  masks [0:2];
    n_vec = 0; n_bad = 0; cyc = 0; rd_cnt = 0; stall_q = 4'd0;
    rd_resp_valid = 1'b0; rd_resp_data = 64'h0;
    req_valid = 1'b0; req_vpn = '0; req_base = '0; req_mask = '0; resp_ready = 1'b0;
    vpns[0]  = 40'h12_3456_789A; bases[0] = 48'h0012_3400_0000; masks[0] = 10'h3FF;
    vpns[1]  = 40'hFF_FFFF_FFFF; bases[1] = 48'h0000_8000_0000; masks[1] = 10'h03F;
    vpns[2]  = 40'h0A_5000_0C31; bases[2] = 48'h7F00_0000_0000; masks[2] = 10'h2D7;
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    chk(req_ready && !resp_valid && !rd_req_valid, "R1 reset state",
        {req_ready, resp_valid, rd_req_valid}, 3'b100);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    for (int c = 0; c < 3; c++) begin
      for (int p = 0; p < 16; p++) run_case(vpns[c], bases[c], masks[c], p);
      run_case(vpns[c], bases[c], masks[c], -1);
    end
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

endmodule